// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Interface

This block is the host-facing port of a timekeeping peripheral that sits on a multiplexed 8-bit address/data bus. Each access has two parts. First an address phase: the host places an address on the shared lines and drops the address strobe. Then a single data phase, in which a byte is read from or written to a 256-byte map. The low 14 bytes of that map are the time and control bytes, and the rest is general storage. A separate extended-RAM select bank sits beside the map.

Two host timing styles share the same strobe pins. In strobe mode one pin is a data strobe and the other carries a read/write level. In split mode the same pins are an active-low read enable and an active-low write strobe. A mode input picks the style while reset is asserted. Every pin is brought through a synchroniser onto a fast system clock, and edges are found by comparing consecutive synchronised samples. The system clock therefore has to run at least four times faster than the narrowest strobe pulse.

The pins are plain strobes and levels with no valid/ready handshake. The host paces every transfer, and the block cannot apply back-pressure. It answers within a fixed number of system clocks after each synchronised edge.

Top module: `mbus_slave`

## Requirements
- R1: The byte on `ad_i` and the level of `xram_i` are captured as the access address on each falling edge of `as_i`, whatever the level of `cs_n_i` at that time.
- R2: In strobe mode (`mode_i` = 1 at reset), a rising edge of `ds_i` while `rw_i` is high starts a read. The block then asserts `ad_oe_o` and presents the addressed byte on `ad_o` until `ds_i` falls.
- R3: In strobe mode, a rising edge of `ds_i` while `rw_i` is low starts a write. The byte on `ad_i` is stored at the falling edge of `ds_i`.
- R4: In split mode (`mode_i` = 0 at reset), a falling edge of `ds_i` starts a read that drives `ad_o` with `ad_oe_o` high until `ds_i` rises again.
- R5: In split mode, `rw_i` is an active-low write strobe. Its falling edge opens the write, and the byte on `ad_i` is stored at its rising edge.
- R6: If `cs_n_i` is high at any sampled point of a data phase, the whole cycle is ignored. No byte is stored, and the bus is not driven from that point on. A read whose select stays high throughout drives nothing.
- R7: With `xram_i` low, addresses 0x00 to 0x0D reach the control bytes and 0x0E to 0xFF reach general storage. With `xram_i` high, the access goes to a separate 128-byte bank indexed by address bits 6:0 (bit 7 is ignored), and the main map is left untouched.
- R8: While `rst_n` is low, `ad_oe_o` is low and strobes are ignored, so a write attempted during reset stores nothing. Stored bytes keep their values through reset.
- R9: `ad_oe_o` is never high during a write cycle, and never while the synchronised chip select is high. `ad_o` reads 0 whenever `ad_oe_o` is low.
- R10: The bus mode is taken from `mode_i` only while reset is asserted. Later changes to `mode_i` have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all bus pins |
| rst_n | input | 1 | Active-low asynchronous reset; bus inaccessible while low |
| mode_i | input | 1 | Bus style: 1 = strobe + read/write level, 0 = split read/write strobes |
| ad_i | input | 8 | Multiplexed address/data lines as seen by the block |
| ad_o | output | 8 | Read data driven toward the shared lines |
| ad_oe_o | output | 1 | Output enable for the pad drivers of the shared lines |
| as_i | input | 1 | Address strobe; falling edge latches the address |
| ds_i | input | 1 | Data strobe (strobe mode) or active-low read enable (split mode) |
| rw_i | input | 1 | Read/write level (strobe mode) or active-low write strobe (split mode) |
| cs_n_i | input | 1 | Active-low chip select, held low through the data phase |
| xram_i | input | 1 | Extended-RAM select, captured with the address |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, 14 control bytes, a 128-byte extended bank and a two-flop synchroniser. With these values the bench can reach the boundary between the control bytes and general storage at 0x0D/0x0E and the top of the map at 0xFF. It can also check that address bit 7 aliases inside the extended bank. Both bus modes are run from separate resets, with mode changes applied after reset, chip-select drops in the middle of a phase, and a write attempted during reset.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  // Bus timing style; values match the mode_i pin level.
  typedef enum logic {
    BUS_SPLIT  = 1'b0,
    BUS_STROBE = 1'b1
  } bus_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

endpackage

// File: rtl/mbus_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
module mbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stage[g-1].r;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].r;

endmodule

// File: rtl/mbus_phase.sv
// Edge detection on synchronised strobes and data-phase sequencing
// for both bus timing styles.
module mbus_phase
  import mbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_mode_e mode,
  input  logic      as_lvl,
  input  logic      ds_lvl,
  input  logic      rw_lvl,
  input  logic      cs_n_lvl,
  output logic      as_fall,
  output logic      rd_en,
  output logic      wr_en
);

  // previous synchronised samples: {as, ds, rw}
  logic [2:0] hist;
  logic       ds_rise, ds_fall, rw_rise, rw_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= 3'b000;
    else        hist <= {as_lvl, ds_lvl, rw_lvl};
  end

  assign as_fall = hist[2] & ~as_lvl;
  assign ds_rise = ~hist[1] & ds_lvl;
  assign ds_fall = hist[1] & ~ds_lvl;
  assign rw_rise = ~hist[0] & rw_lvl;
  assign rw_fall = hist[0] & ~rw_lvl;

  phase_e st, st_nxt;
  logic   sel_ok, sel_ok_nxt;

  always_comb begin
    st_nxt     = st;
    sel_ok_nxt = sel_ok & ~cs_n_lvl;
    wr_en      = 1'b0;
    unique case (mode)
      BUS_STROBE: begin
        if (st == PH_IDLE) begin
          if (ds_rise) begin
            st_nxt     = rw_lvl ? PH_READ : PH_WRITE;
            sel_ok_nxt = ~cs_n_lvl;
          end
        end else if (ds_fall) begin
          wr_en  = (st == PH_WRITE) && sel_ok_nxt;
          st_nxt = PH_IDLE;
        end
      end
      default: begin
        unique case (st)
          PH_IDLE: begin
            if (ds_fall) begin
              st_nxt     = PH_READ;
              sel_ok_nxt = ~cs_n_lvl;
            end else if (rw_fall) begin
              st_nxt     = PH_WRITE;
              sel_ok_nxt = ~cs_n_lvl;
            end
          end
          PH_READ: begin
            if (ds_rise) st_nxt = PH_IDLE;
          end
          PH_WRITE: begin
            if (rw_rise) begin
              wr_en  = sel_ok_nxt;
              st_nxt = PH_IDLE;
            end
          end
          default: st_nxt = PH_IDLE;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PH_IDLE;
      sel_ok <= 1'b0;
    end else begin
      st     <= st_nxt;
      sel_ok <= sel_ok_nxt;
    end
  end

  assign rd_en = (st == PH_READ) && sel_ok && !cs_n_lvl;

endmodule

// File: rtl/mbus_store.sv
// Control bytes, general storage and the extended bank.
module mbus_store #(
  parameter int DATA_W     = 8,
  parameter int CTL_BYTES  = 14,
  parameter int XRAM_DEPTH = 128
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              xram_sel,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int MAP_DEPTH = 1 << DATA_W;
  localparam int GEN_DEPTH = MAP_DEPTH - CTL_BYTES;
  localparam int CTL_AW    = $clog2(CTL_BYTES);

  logic [DATA_W-1:0] ctl_mem [CTL_BYTES];
  logic [DATA_W-1:0] gen_mem [GEN_DEPTH];
  logic              in_ctl;
  logic [DATA_W-1:0] gen_idx;
  logic [DATA_W-1:0] main_rd, xram_rd;

  assign in_ctl  = addr < DATA_W'(CTL_BYTES);
  assign gen_idx = addr - DATA_W'(CTL_BYTES);

  always_ff @(posedge clk) begin
    if (wr_en && !xram_sel) begin
      if (in_ctl) ctl_mem[addr[CTL_AW-1:0]] <= wdata;
      else        gen_mem[gen_idx]          <= wdata;
    end
  end

  assign main_rd = in_ctl ? ctl_mem[addr[CTL_AW-1:0]] : gen_mem[gen_idx];

  if (XRAM_DEPTH > 1) begin : g_xram
    localparam int XAW = $clog2(XRAM_DEPTH);
    logic [DATA_W-1:0] x_mem [XRAM_DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && xram_sel) x_mem[addr[XAW-1:0]] <= wdata;
    end
    assign xram_rd = x_mem[addr[XAW-1:0]];
  end else begin : g_no_xram
    assign xram_rd = '1;
  end

  assign rdata = xram_sel ? xram_rd : main_rd;

endmodule

// File: rtl/mbus_slave.sv
// Dual-mode multiplexed address/data bus slave.
module mbus_slave
  import mbus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CTL_BYTES   = 14,
  parameter int XRAM_DEPTH  = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rw_i,
  input  logic              cs_n_i,
  input  logic              xram_i
);

  // synchronised vector: {xram, cs_n, as, ds, rw, ad}
  localparam int           SW      = DATA_W + 5;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 3'b000, {DATA_W{1'b0}}};

  logic [SW-1:0]     pins_s;
  logic [DATA_W-1:0] ad_s;
  logic              xram_s, cs_n_s, as_s, ds_s, rw_s;

  mbus_sync #(
    .W       (SW),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({xram_i, cs_n_i, as_i, ds_i, rw_i, ad_i}),
    .q_o   (pins_s)
  );

  assign {xram_s, cs_n_s, as_s, ds_s, rw_s, ad_s} = pins_s;

  // bus style is fixed while reset is held
  bus_mode_e mode_q;
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= bus_mode_e'(mode_i);
  end

  logic as_fall, rd_en, wr_en;

  mbus_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .as_lvl   (as_s),
    .ds_lvl   (ds_s),
    .rw_lvl   (rw_s),
    .cs_n_lvl (cs_n_s),
    .as_fall  (as_fall),
    .rd_en    (rd_en),
    .wr_en    (wr_en)
  );

  logic [DATA_W-1:0] addr_q;
  logic              xram_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      xram_q <= 1'b0;
    end else if (as_fall) begin
      addr_q <= ad_s;
      xram_q <= xram_s;
    end
  end

  logic [DATA_W-1:0] rdata;

  mbus_store #(
    .DATA_W     (DATA_W),
    .CTL_BYTES  (CTL_BYTES),
    .XRAM_DEPTH (XRAM_DEPTH)
  ) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .xram_sel (xram_q),
    .addr     (addr_q),
    .wdata    (ad_s),
    .rdata    (rdata)
  );

  assign ad_oe_o = rd_en;
  assign ad_o    = rd_en ? rdata : '0;

endmodule

// File: rtl/mbus_slave_chk.sv
module mbus_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe,
  input logic [DATA_W-1:0] dout,
  input logic              cs_lvl,
  input logic              wr_en,
  input logic              as_fall,
  input logic [DATA_W-1:0] addr_q,
  input logic              mode_q
);

  // R8: no drive while reset is low
  always_comb begin
    if (!rst_n) a_r8_silent_in_reset: assert (!oe);
  end

  // R9: deselected block leaves the bus alone
  a_r9_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |-> !oe);

  // R9: a store never coincides with driving
  a_r9_no_drive_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !oe);

  // R1: address only moves on an address-strobe fall
  a_r1_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !as_fall |=> $stable(addr_q));

  // R10: latched bus style is constant out of reset
  a_r10_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

  // R2: driven byte holds steady through a read
  a_r2_read_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe)) |-> $stable(dout));

endmodule

bind mbus_slave mbus_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .oe      (ad_oe_o),
  .dout    (ad_o),
  .cs_lvl  (cs_n_s),
  .wr_en   (wr_en),
  .as_fall (as_fall),
  .addr_q  (addr_q),
  .mode_q  (mode_q)
);

// File: tb/sim_mbus_slave.sv
module sim_mbus_slave;

  localparam int CLK_NS   = 10;
  localparam int SETTLE   = 4;
  localparam int WDOG_CYC = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_i = 1'b1;
  logic [7:0] ad_i = 8'h00;
  logic [7:0] ad_o;
  logic       ad_oe_o;
  logic       as_i = 1'b0, ds_i = 1'b0, rw_i = 1'b1, cs_n_i = 1'b1, xram_i = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  mbus_slave u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ad_i(ad_i), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .as_i(as_i), .ds_i(ds_i), .rw_i(rw_i),
    .cs_n_i(cs_n_i), .xram_i(xram_i)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  bit    cur_strobe = 1'b1;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic apply_reset(input bit strobe_mode);
    rst_n = 1'b0;
    mode_i = strobe_mode;
    cur_strobe = strobe_mode;
    as_i = 1'b0; cs_n_i = 1'b1; rw_i = 1'b1;
    ds_i = strobe_mode ? 1'b0 : 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic addr_phase(input logic [7:0] a, input bit x);
    ad_i = a; xram_i = x; as_i = 1'b1;
    settle();
    as_i = 1'b0;
    settle();
  endtask

  task automatic cs_glitch(input bit en);
    if (en) begin
      cs_n_i = 1'b1; settle(); cs_n_i = 1'b0; settle();
    end
  endtask

  task automatic do_write(input logic [7:0] a, input bit x, input logic [7:0] d,
                          input bit drop, input bit sel_high);
    addr_phase(a, x);
    ad_i = d; cs_n_i = sel_high;
    if (cur_strobe) begin
      rw_i = 1'b0; settle();
      ds_i = 1'b1; settle();
      cs_glitch(drop);
      ds_i = 1'b0; settle();
      rw_i = 1'b1;
    end else begin
      settle();
      rw_i = 1'b0; settle();
      cs_glitch(drop);
      rw_i = 1'b1; settle();
    end
    cs_n_i = 1'b1;
    settle();
  endtask

  // expected byte goes to the scoreboard; monitor compares on drive
  task automatic do_read(input logic [7:0] a, input bit x, input logic [7:0] exp,
                         input bit drive, input string tag);
    if (drive) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    addr_phase(a, x);
    cs_n_i = !drive;
    rw_i = 1'b1;
    if (cur_strobe) begin
      settle(); ds_i = 1'b1; settle(); settle(); ds_i = 1'b0;
    end else begin
      settle(); ds_i = 1'b0; settle(); settle(); ds_i = 1'b1;
    end
    settle();
    cs_n_i = 1'b1;
    settle();
    check({tag, " missing drive"}, 8'(exp_q.size()), 8'd0);
    exp_q.delete();
    tag_q.delete();
  endtask

  // monitor: every new drive must match the front of the scoreboard
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (ad_oe_o && !prev_oe) begin
      if (exp_q.size() == 0) begin
        check("R9/R6 unexpected drive", 8'(ad_oe_o), 8'd0);
      end else begin
        check(tag_q.pop_front(), ad_o, exp_q.pop_front());
      end
    end
    if (!ad_oe_o && ad_o !== 8'h00) check("R9 idle output", ad_o, 8'h00);
    prev_oe = ad_oe_o;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=finished", WDOG_CYC);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // strobe mode
    apply_reset(1'b1);
    check("R8 reset oe", 8'(ad_oe_o), 8'd0);
    check("R8 reset data", ad_o, 8'h00);

    do_write(8'h00, 1'b0, 8'h3C, 1'b0, 1'b0);   // R3
    do_write(8'h0D, 1'b0, 8'hA5, 1'b0, 1'b0);   // R3, R7 last control byte
    do_write(8'h0E, 1'b0, 8'h5A, 1'b0, 1'b0);   // R7 first general byte
    do_write(8'hFF, 1'b0, 8'h81, 1'b0, 1'b0);   // R7 top
    do_read(8'h00, 1'b0, 8'h3C, 1'b1, "R2 ctl byte 0");
    do_read(8'h0D, 1'b0, 8'hA5, 1'b1, "R7 ctl byte 13");
    do_read(8'h0E, 1'b0, 8'h5A, 1'b1, "R7 general 0x0E");
    do_read(8'hFF, 1'b0, 8'h81, 1'b1, "R1 R2 top address");

    // R7 extended bank
    do_write(8'h0D, 1'b1, 8'h77, 1'b0, 1'b0);
    do_read(8'h0D, 1'b0, 8'hA5, 1'b1, "R7 main map untouched");
    do_read(8'h0D, 1'b1, 8'h77, 1'b1, "R7 xram byte");
    do_read(8'h8D, 1'b1, 8'h77, 1'b1, "R7 xram bit7 ignored");

    // R6 select violations
    do_write(8'h0D, 1'b0, 8'h00, 1'b1, 1'b0);
    do_read(8'h0D, 1'b0, 8'hA5, 1'b1, "R6 select drop write");
    do_write(8'h0E, 1'b0, 8'h00, 1'b0, 1'b1);
    do_read(8'h0E, 1'b0, 8'h5A, 1'b1, "R6 deselected write");
    do_read(8'h0E, 1'b0, 8'h00, 1'b0, "R6 deselected read");

    // R10 mode pin change after reset
    mode_i = 1'b0;
    do_write(8'h20, 1'b0, 8'h99, 1'b0, 1'b0);
    do_read(8'h20, 1'b0, 8'h99, 1'b1, "R10 strobe mode kept");

    // R8 write attempted during reset
    mode_i = 1'b1;
    rst_n = 1'b0;
    do_write(8'h20, 1'b0, 8'h11, 1'b0, 1'b0);
    check("R8 oe in reset", 8'(ad_oe_o), 8'd0);
    rst_n = 1'b1;
    settle();
    do_read(8'h20, 1'b0, 8'h99, 1'b1, "R8 write in reset ignored");

    // split mode
    apply_reset(1'b0);
    check("R8 reset oe split", 8'(ad_oe_o), 8'd0);
    do_write(8'h40, 1'b0, 8'hC3, 1'b0, 1'b0);   // R5
    do_write(8'h0C, 1'b0, 8'h18, 1'b0, 1'b0);   // R5
    do_read(8'h40, 1'b0, 8'hC3, 1'b1, "R4 R5 general byte");
    do_read(8'h0C, 1'b0, 8'h18, 1'b1, "R4 R5 ctl byte");
    do_read(8'h00, 1'b0, 8'h3C, 1'b1, "R8 storage kept over reset");
    do_write(8'h40, 1'b0, 8'h00, 1'b1, 1'b0);
    do_read(8'h40, 1'b0, 8'hC3, 1'b1, "R6 split select drop");
    do_read(8'h40, 1'b0, 8'h00, 1'b0, "R6 split deselected read");
    mode_i = 1'b1;
    do_write(8'h41, 1'b0, 8'h6E, 1'b0, 1'b0);
    do_read(8'h41, 1'b0, 8'h6E, 1'b1, "R10 split mode kept");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule